// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block keeps a 16-bit baud divisor and turns the serial clock into the timing strobes a UART needs. A one-cycle oversample strobe fires once every divisor serial-clock cycles. A bit-rate strobe fires on every sixteenth oversample strobe, so the bit rate is the serial clock frequency over sixteen times the divisor.

The divisor is reached through two byte-wide registers on a small register bus. Address 0 selects the low byte and address 1 selects the high byte. An access is honoured only while the divisor-access input (bit 7 of the line control register, supplied from outside) is 1 and the UART busy input is 0. A divisor of zero stops every strobe.

Each accepted write restarts the oversample period from the new value. It also pulls the ready output low for eight serial-clock cycles, so the transmitter and receiver know when they may start.

Top module: `baud_divisor_gen`

## Requirements
- R1: After reset both divisor bytes read as zero, ready is low, and neither strobe fires.
- R2: With acc_en=1 and uart_busy=0, a write stores reg_wdata in the low byte (reg_addr=0) or the high byte (reg_addr=1). A read returns that byte on reg_rdata in the cycle after the read edge.
- R3: A write made while acc_en=0 or uart_busy=1 leaves both bytes unchanged and does not disturb ready.
- R4: A read made while acc_en=0 or uart_busy=1 returns zero on reg_rdata.
- R5: With a divisor D of 2 or more, os_tick is a one-cycle pulse repeating every D cycles. The first pulse appears D+1 cycles after the clock edge of the last accepted write.
- R6: With D equal to 1, os_tick is high on every cycle from the second cycle after the write onward.
- R7: bit_tick pulses together with every sixteenth os_tick, counted from the last accepted write, so its period is 16*D cycles.
- R8: While both divisor bytes are zero, os_tick and bit_tick stay low and ready stays low.
- R9: After an accepted write, ready is low for the 8 cycles that follow its clock edge. It is high from then on while the divisor is nonzero.
- R10: An accepted write, even of an unchanged value, discards the partial period in progress. The oversample and bit phases restart from that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 1 | Byte select: 0 low, 1 high |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, registered |
| acc_en | input | 1 | Divisor-access control bit |
| uart_busy | input | 1 | UART busy status |
| os_tick | output | 1 | Oversample strobe |
| bit_tick | output | 1 | Bit-rate strobe |
| ready | output | 1 | Divisor settled and nonzero |

## Verification
The assertions watch several properties on every cycle. A refused write leaves the divisor untouched, and a refused read returns zero. A zero divisor keeps both strobes quiet. bit_tick never fires without os_tick. A divisor of one repeats os_tick back to back. An accepted write drops ready and silences the next strobe. Only the bench scenarios can show the exact spacing of strobes for a given divisor, the sixteen-to-one ratio, the length of the eight-cycle settle window, and the phase restart after a rewrite, because each of these needs a count over many cycles.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned NUM_BYTES = 2;
  localparam int unsigned ADDR_W    = 1;
  localparam logic [ADDR_W-1:0] ADDR_LO = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_HI = 1'b1;
endpackage

// File: rtl/baud_divreg.sv
module baud_divreg
  import baud_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DIV_W = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              acc_en,
  input  logic              uart_busy,
  output logic [DIV_W-1:0]  div_q,
  output logic              wr_hit,
  output logic              div_upd
);
  logic allow;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes_q;

  assign allow  = acc_en & ~uart_busy;
  assign wr_hit = reg_wr & allow;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        bytes_q[b] <= '0;
      else if (wr_hit && reg_addr == ADDR_W'(b))
        bytes_q[b] <= reg_wdata;
    end
    assign div_q[b*BYTE_W +: BYTE_W] = bytes_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      div_upd   <= 1'b0;
    end else begin
      div_upd   <= wr_hit;
      reg_rdata <= (reg_rd && allow) ? bytes_q[reg_addr] : '0;
    end
  end

  AST_BLOCKED_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (!acc_en || uart_busy)) |=> $stable(div_q)); // R3
  AST_BLOCKED_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (!acc_en || uart_busy)) |=> (reg_rdata == '0)); // R4
endmodule

// File: rtl/baud_tickgen.sv
module baud_tickgen #(
  parameter int unsigned DIV_W      = 16,
  parameter int unsigned OS_PER_BIT = 16,
  localparam int unsigned BC_W      = $clog2(OS_PER_BIT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_q,
  input  logic             div_upd,
  output logic             os_tick,
  output logic             bit_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [BC_W-1:0]  bc_q;
  logic             div_zero;
  logic [DIV_W-1:0] reload;

  assign div_zero = (div_q == '0);
  assign reload   = div_zero ? '0 : div_q - DIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      bc_q     <= '0;
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else if (div_upd || div_zero) begin
      cnt_q    <= reload;
      bc_q     <= '0;
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q    <= reload;
      bc_q     <= (bc_q == BC_W'(OS_PER_BIT - 1)) ? '0 : bc_q + BC_W'(1);
      os_tick  <= 1'b1;
      bit_tick <= (bc_q == BC_W'(OS_PER_BIT - 1));
    end else begin
      cnt_q    <= cnt_q - DIV_W'(1);
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end
  end

  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
    (div_q == '0) |=> (!os_tick && !bit_tick)); // R8
  AST_BIT_ON_OS: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> os_tick); // R7
  AST_DIV1_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (div_q == DIV_W'(1) && os_tick && !div_upd) |=> os_tick); // R6
  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    div_upd |=> !os_tick); // R10
endmodule

// File: rtl/baud_settle.sv
module baud_settle #(
  parameter int unsigned SETTLE_CYC = 8,
  localparam int unsigned SC_W      = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic div_nz,
  output logic ready
);
  logic [SC_W-1:0] scnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scnt_q <= '0;
      ready  <= 1'b0;
    end else if (wr_hit) begin
      scnt_q <= SC_W'(SETTLE_CYC);
      ready  <= 1'b0;
    end else if (scnt_q != '0) begin
      scnt_q <= scnt_q - SC_W'(1);
      ready  <= (scnt_q == SC_W'(1)) && div_nz;
    end else begin
      ready  <= div_nz;
    end
  end

  AST_WR_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> !ready); // R9
  AST_READY_NEEDS_NZ: assert property (@(posedge clk) disable iff (rst)
    ready |-> div_nz); // R9
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ready && !wr_hit) |=> ready); // R9
endmodule

// File: rtl/baud_divisor_gen.sv
module baud_divisor_gen
  import baud_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned OS_PER_BIT = 16,
  parameter int unsigned SETTLE_CYC = 8,
  localparam int unsigned DIV_W     = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              acc_en,
  input  logic              uart_busy,
  output logic              os_tick,
  output logic              bit_tick,
  output logic              ready
);
  logic [DIV_W-1:0] div_q;
  logic             wr_hit;
  logic             div_upd;

  baud_divreg #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .acc_en(acc_en), .uart_busy(uart_busy), .div_q(div_q),
    .wr_hit(wr_hit), .div_upd(div_upd)
  );

  baud_tickgen #(.DIV_W(DIV_W), .OS_PER_BIT(OS_PER_BIT)) u_ticks (
    .clk(clk), .rst(rst), .div_q(div_q), .div_upd(div_upd),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  baud_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .div_nz(div_q != '0),
    .ready(ready)
  );
endmodule

// File: tb/sim_baud_divisor_gen.sv
module sim_baud_divisor_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_addr = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       acc_en = 1'b1;
  logic       uart_busy = 1'b0;
  logic       os_tick, bit_tick, ready;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] m_lo = '0, m_hi = '0;

  baud_divisor_gen u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .acc_en(acc_en), .uart_busy(uart_busy), .os_tick(os_tick),
    .bit_tick(bit_tick), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_os(int d, int k);
    if (d == 0 || k < d + 1) return 1'b0;
    return ((k - d - 1) % d) == 0;
  endfunction

  function automatic bit exp_bit(int d, int k);
    if (!exp_os(d, k)) return 1'b0;
    return (((k - d - 1) / d) % 16) == 15;
  endfunction

  task automatic wr_reg(logic a, logic [7:0] d, logic acc, logic bsy);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; acc_en = acc; uart_busy = bsy;
    @(negedge clk);
    reg_wr = 1'b0; acc_en = 1'b1; uart_busy = 1'b0;
    if (acc && !bsy) begin
      if (a) m_hi = d;
      else   m_lo = d;
    end
  endtask

  task automatic rd_reg(logic a, logic acc, logic bsy, output logic [7:0] q);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1; acc_en = acc; uart_busy = bsy;
    @(negedge clk);
    q = reg_rdata;
    reg_rd = 1'b0; acc_en = 1'b1; uart_busy = 1'b0;
  endtask

  // k = 0 is the sample right after the edge of the last accepted write
  task automatic run_check(int ncyc, string os_tag);
    int d;
    d = {16'd0, m_hi, m_lo};
    for (int k = 0; k < ncyc; k++) begin
      chk((d == 0) ? "R8" : "R9", "ready", int'(ready), int'((d != 0) && (k >= 8)));
      if (k >= 1) begin
        chk((d == 0) ? "R8" : os_tag, "os_tick", int'(os_tick), int'(exp_os(d, k)));
        chk((d == 0) ? "R8" : "R7", "bit_tick", int'(bit_tick), int'(exp_bit(d, k)));
      end
      @(negedge clk);
    end
  endtask

  task automatic set_div(int d, string os_tag, int extra);
    wr_reg(1'b1, d[15:8], 1'b1, 1'b0);
    wr_reg(1'b0, d[7:0], 1'b1, 1'b0);
    run_check(16 * d + d + extra, os_tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int i = 0; i < 20; i++) begin
      chk("R1", "ready", int'(ready), 0);
      chk("R1", "os_tick", int'(os_tick), 0);
      chk("R1", "bit_tick", int'(bit_tick), 0);
      @(negedge clk);
    end
    rd_reg(1'b0, 1'b1, 1'b0, q); chk("R1", "low byte", int'(q), 0);
    rd_reg(1'b1, 1'b1, 1'b0, q); chk("R1", "high byte", int'(q), 0);

    // R2: allowed access
    wr_reg(1'b0, 8'h5A, 1'b1, 1'b0);
    wr_reg(1'b1, 8'h03, 1'b1, 1'b0);
    rd_reg(1'b0, 1'b1, 1'b0, q); chk("R2", "low byte", int'(q), 8'h5A);
    rd_reg(1'b1, 1'b1, 1'b0, q); chk("R2", "high byte", int'(q), 8'h03);
    repeat (10) @(negedge clk);
    chk("R9", "ready settled", int'(ready), 1);

    // R3: blocked writes
    wr_reg(1'b0, 8'hFF, 1'b0, 1'b0);
    chk("R3", "ready after blocked write", int'(ready), 1);
    wr_reg(1'b1, 8'hEE, 1'b1, 1'b1);
    chk("R3", "ready after busy write", int'(ready), 1);
    rd_reg(1'b0, 1'b1, 1'b0, q); chk("R3", "low byte kept", int'(q), 8'h5A);
    rd_reg(1'b1, 1'b1, 1'b0, q); chk("R3", "high byte kept", int'(q), 8'h03);

    // R4: blocked reads
    rd_reg(1'b0, 1'b0, 1'b0, q); chk("R4", "read acc_en=0", int'(q), 0);
    rd_reg(1'b1, 1'b1, 1'b1, q); chk("R4", "read busy", int'(q), 0);
    rd_reg(1'b0, 1'b0, 1'b1, q); chk("R4", "read both blocked", int'(q), 0);

    // R2/R3/R4: random accesses against the bench model
    for (int i = 0; i < 30; i++) begin
      logic a, acc, bsy;
      logic [7:0] d;
      a = 1'($urandom); acc = 1'($urandom); bsy = 1'($urandom); d = 8'($urandom);
      wr_reg(a, d, acc, bsy);
      a = 1'($urandom);
      rd_reg(a, 1'b1, 1'b0, q);
      chk((acc && !bsy) ? "R2" : "R3", "readback", int'(q), int'(a ? m_hi : m_lo));
      acc = 1'($urandom); bsy = 1'($urandom);
      rd_reg(a, acc, bsy, q);
      chk((acc && !bsy) ? "R2" : "R4", "read gated", int'(q),
          int'((acc && !bsy) ? (a ? m_hi : m_lo) : 8'h00));
    end

    // R8: zero divisor
    wr_reg(1'b1, 8'h00, 1'b1, 1'b0);
    wr_reg(1'b0, 8'h00, 1'b1, 1'b0);
    run_check(60, "R8");

    // R6: divisor of one
    set_div(1, "R6", 20);

    // R5/R7: directed divisors
    set_div(3, "R5", 10);
    set_div(16'h0102, "R5", 10);

    // R10: rewrite mid-period restarts phase
    wr_reg(1'b1, 8'h00, 1'b1, 1'b0);
    wr_reg(1'b0, 8'd10, 1'b1, 1'b0);
    run_check(15, "R5");
    wr_reg(1'b0, 8'd10, 1'b1, 1'b0);
    run_check(180, "R10");

    // R5/R7: random divisors
    for (int i = 0; i < 8; i++) begin
      int d;
      d = 2 + int'($urandom % 39);
      set_div(d, "R5", 5);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule